// File: doc/BRIEF.md
# Quadrature Step Decoder with Selectable Resolution

This block turns the two raw phase signals of a mechanical rotary encoder into step commands for a separate binary position counter. It does not hold a count itself. Each clock cycle it may emit a one-cycle count-enable pulse together with an up/down direction, and the counter that sits next to it adds or subtracts one on that pulse.

Both phase inputs are synchronized into the system clock domain, and a history register keeps the previous synchronized pair. Every clock cycle the block compares the current pair with the previous one. A change of exactly one phase is a legal quarter-cycle move and carries a direction. A change of both phases at once is a skipped state and is discarded. A two-bit resolution select gives one, two or four counts per full electrical cycle, all from the same state tracking. The counting edges are chosen so that contact chatter on one phase always produces matching up and down steps.

Top module: `quad_step_decoder`

## Requirements
- R1: Each phase input passes through a two-flop synchronizer and one history register. When a phase change is first sampled at rising edge k, the matching `step_en` pulse and the updated `step_up` appear after rising edge k+2.
- R2: While `rst_n` is low at a rising edge, `step_en` and `step_up` become 0 and the synchronizers and history are cleared to A=0, B=0.
- R3: When only A changes, the direction is up (`step_up`=1) if the previous A equalled the previous B, and down otherwise.
- R4: When only B changes, the direction is up if the previous A differed from the previous B, and down otherwise.
- R5: When A and B change in the same cycle, no count is enabled, and the history still takes the new pair.
- R6: With `res_mode` = 2'b10 or 2'b11 (four counts per cycle), every single-phase change enables one count.
- R7: With `res_mode` = 2'b01 (two counts per cycle), only changes of A alone enable a count.
- R8: With `res_mode` = 2'b00 (one count per cycle), only a change of A alone while B is 1 enables a count.
- R9: `step_en` is high for exactly one cycle per counted transition. `step_up` changes only in a cycle where `step_en` is high, and otherwise holds its value.
- R10: If one phase toggles back and forth an even number of times around any state, the up and down steps cancel in every mode. The attached counter shows no net change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_a | input | 1 | Raw encoder phase A (asynchronous) |
| phase_b | input | 1 | Raw encoder phase B (asynchronous) |
| res_mode | input | 2 | Resolution: 00 one, 01 two, 10/11 four counts per cycle |
| step_en | output | 1 | One-cycle count enable for the external counter |
| step_up | output | 1 | Direction for the external counter: 1 up, 0 down |

## Verification
The assertions check four things on every cycle. Both outputs are clear after a reset cycle. `step_up` moves only together with a `step_en` pulse. No pulse can appear once both phases have been quiet for long enough to drain the pipeline. Which transitions count in each resolution, the direction for each of the eight single-phase moves, the discarding of double changes, the exact three-edge latency and the cancellation of chatter can only be shown by the bench's scenarios. The bench compares those against its own per-cycle model and a position counter it keeps itself.

// File: rtl/quad_pkg.sv
// Shared types for the quadrature step decoder.
// Assumes phase pairs are carried with A in the upper bit.
package quad_pkg;
    typedef enum logic [1:0] {
        RES_X1  = 2'b00,
        RES_X2  = 2'b01,
        RES_X4  = 2'b10,
        RES_X4B = 2'b11
    } res_mode_e;

    typedef struct packed {
        logic a;
        logic b;
    } phase_t;
endpackage

// File: rtl/quad_sync.sv
// Multi-bit synchronizer: each bit gets its own chain of STAGES flops.
// Assumes the bits are independent (no coherence between bits is implied).
module quad_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift the raw bit through the chain; synchronous clear.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din[i]};
            end
            assign dout[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/quad_xition.sv
// Transition classifier: compares the current and previous phase pairs.
// Flags a legal single-phase move, tells whether A or B moved, and gives
// its direction. A double change is reported as not legal.
module quad_xition
    import quad_pkg::*;
(
    input  phase_t cur,
    input  phase_t prev,
    output logic   single_move,
    output logic   a_moved,
    output logic   dir_up
);
    logic a_chg, b_chg, prev_eq;

    // Classify the move and derive its direction from the previous pair.
    always_comb begin
        a_chg       = cur.a ^ prev.a;
        b_chg       = cur.b ^ prev.b;
        prev_eq     = (prev.a == prev.b);
        single_move = a_chg ^ b_chg;
        a_moved     = a_chg & ~b_chg;
        dir_up      = a_moved ? prev_eq : ~prev_eq;
    end
endmodule

// File: rtl/quad_gate.sv
// Resolution gate and output register. Decides whether a legal move
// counts under the selected resolution, then registers a one-cycle enable
// and a held direction. Assumes the classifier inputs settle within a cycle.
module quad_gate
    import quad_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  res_mode_e mode,
    input  logic      single_move,
    input  logic      a_moved,
    input  logic      cur_b,
    input  logic      dir_up,
    output logic      step_en,
    output logic      step_up
);
    logic counts;

    // Pick the counting transitions for the selected resolution.
    always_comb begin
        unique case (mode)
            RES_X1:  counts = a_moved & cur_b;
            RES_X2:  counts = a_moved;
            default: counts = single_move;
        endcase
    end

    // Register the pulse; direction only moves with a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_en <= 1'b0;
            step_up <= 1'b0;
        end else begin
            step_en <= counts;
            if (counts) step_up <= dir_up;
        end
    end
endmodule

// File: rtl/quad_step_decoder.sv
// Top: synchronizes raw A/B, keeps one history pair, classifies each move
// and emits step enable/direction at 1x, 2x or 4x resolution.
// Assumes the phases are asynchronous to clk and change slower than clk.
module quad_step_decoder
    import quad_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase_a,
    input  logic       phase_b,
    input  logic [1:0] res_mode,
    output logic       step_en,
    output logic       step_up
);
    localparam int PHASES = $bits(phase_t);

    logic [PHASES-1:0] synced;
    phase_t            cur_ph, prev_ph;
    logic              single_move, a_moved, dir_up;
    res_mode_e         mode;

    quad_sync #(.STAGES(SYNC_STAGES), .WIDTH(PHASES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({phase_a, phase_b}),
        .dout  (synced)
    );

    assign cur_ph = phase_t'(synced);
    assign mode   = res_mode_e'(res_mode);

    // History register: always follows the synchronized pair.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ph <= '0;
        else        prev_ph <= cur_ph;
    end

    quad_xition u_xition (
        .cur         (cur_ph),
        .prev        (prev_ph),
        .single_move (single_move),
        .a_moved     (a_moved),
        .dir_up      (dir_up)
    );

    quad_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .single_move (single_move),
        .a_moved     (a_moved),
        .cur_b       (cur_ph.b),
        .dir_up      (dir_up),
        .step_en     (step_en),
        .step_up     (step_up)
    );
endmodule

// File: rtl/quad_step_decoder_chk.sv
// Checker for quad_step_decoder, attached by bind. Watches only ports.
// Assumes inputs are quiet while reset is held at the start.
module quad_step_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       phase_a,
    input logic       phase_b,
    input logic [1:0] res_mode,
    input logic       step_en,
    input logic       step_up
);
    logic [1:0] last_ph;
    logic [2:0] quiet_cnt;

    // Count cycles in which both raw phases stayed unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ph   <= 2'b00;
            quiet_cnt <= '0;
        end else begin
            last_ph <= {phase_a, phase_b};
            if ({phase_a, phase_b} != last_ph) quiet_cnt <= '0;
            else if (quiet_cnt != 3'd7)        quiet_cnt <= quiet_cnt + 3'd1;
        end
    end

    // R2: reset clears the enable
    a_r2_reset_en: assert property (@(posedge clk) !rst_n |=> !step_en);
    // R2: reset clears the direction
    a_r2_reset_up: assert property (@(posedge clk) !rst_n |=> !step_up);
    // R9: direction moves only with a pulse
    a_r9_up_with_en: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up != $past(step_up)) |-> step_en);
    // R1: a drained pipeline gives no pulse
    a_r1_quiet_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt >= 3'd4) |-> !step_en);
endmodule

bind quad_step_decoder quad_step_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_a  (phase_a),
    .phase_b  (phase_b),
    .res_mode (res_mode),
    .step_en  (step_en),
    .step_up  (step_up)
);

// File: tb/tb_quad_step_decoder.sv
module tb_quad_step_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase_a = 1'b0;
    logic       phase_b = 1'b0;
    logic [1:0] res_mode = 2'b10;
    logic       step_en, step_up;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R2";
    bit    done = 1'b0;

    logic [1:0] hq[$] = '{2'b00, 2'b00, 2'b00, 2'b00};
    logic exp_en = 1'b0;
    logic exp_up = 1'b0;
    int   pos = 0;

    always #2 clk = ~clk;

    quad_step_decoder dut (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .res_mode(res_mode), .step_en(step_en), .step_up(step_up)
    );

    // Behavioural reference: queue of sampled pairs, decode from requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            hq = '{2'b00, 2'b00, 2'b00, 2'b00};
            exp_en = 1'b0;
            exp_up = 1'b0;
        end else begin
            logic [1:0] c, p;
            logic ach, bch, up, cnt;
            hq.push_front({phase_a, phase_b});
            hq = hq[0:3];
            c = hq[2];
            p = hq[3];
            ach = c[1] != p[1];
            bch = c[0] != p[0];
            up  = ach ? (p[1] == p[0]) : (p[1] != p[0]);
            if (res_mode[1])        cnt = ach ^ bch;
            else if (res_mode[0])   cnt = ach && !bch;
            else                    cnt = ach && !bch && c[0];
            exp_en = cnt;
            if (cnt) exp_up = up;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle away from the active edge; keep a position count.
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, step_en, exp_en, "step_en");
            check(cur_req, step_up, exp_up, "step_up");
            if (step_en) pos += step_up ? 1 : -1;
        end
    end

    task automatic drive(input logic a, input logic b, input int hold);
        @(negedge clk);
        phase_a = a;
        phase_b = b;
        repeat (hold - 1) @(negedge clk);
    endtask

    // Walk n quarter steps forward (00,10,11,01) or backward.
    task automatic walk(input bit fwd, input int n, input int hold);
        for (int i = 0; i < n; i++) begin
            logic [1:0] s;
            s = {phase_a, phase_b};
            if (fwd) s = (s == 2'b00) ? 2'b10 : (s == 2'b10) ? 2'b11 : (s == 2'b11) ? 2'b01 : 2'b00;
            else     s = (s == 2'b00) ? 2'b01 : (s == 2'b01) ? 2'b11 : (s == 2'b11) ? 2'b10 : 2'b00;
            drive(s[1], s[0], hold);
        end
    endtask

    initial begin
        int p0;
        // R2: reset state
        repeat (3) @(negedge clk);
        check("R2", step_en, 0, "reset en");
        check("R2", step_up, 0, "reset up");
        rst_n = 1'b1;

        // R1: latency of exactly three edges, 4x mode
        cur_req = "R1";
        res_mode = 2'b10;
        repeat (3) @(negedge clk);
        phase_a = 1'b1;
        @(negedge clk); check("R1", step_en, 0, "edge1");
        @(negedge clk); check("R1", step_en, 0, "edge2");
        @(negedge clk); check("R1", step_en, 1, "edge3");
        check("R3", step_up, 1, "A move from equal pair");
        @(negedge clk); check("R9", step_en, 0, "single pulse");
        drive(0, 0, 5);

        // R6 / R3 / R4: 4x forward and reverse
        cur_req = "R6"; p0 = pos;
        walk(1, 8, 5); repeat (4) @(negedge clk);
        check("R6", pos - p0, 8, "4x forward net");
        cur_req = "R4"; p0 = pos;
        walk(0, 8, 5); repeat (4) @(negedge clk);
        check("R4", pos - p0, -8, "4x reverse net");
        res_mode = 2'b11; cur_req = "R6"; p0 = pos;
        walk(1, 4, 3); repeat (4) @(negedge clk);
        check("R6", pos - p0, 4, "mode 11 forward net");

        // R7: 2x
        res_mode = 2'b01; cur_req = "R7"; p0 = pos;
        walk(1, 8, 4); repeat (4) @(negedge clk);
        check("R7", pos - p0, 4, "2x forward net");
        p0 = pos;
        walk(0, 4, 4); repeat (4) @(negedge clk);
        check("R7", pos - p0, -2, "2x reverse net");

        // R8: 1x
        res_mode = 2'b00; cur_req = "R8"; p0 = pos;
        walk(1, 8, 4); repeat (4) @(negedge clk);
        check("R8", pos - p0, 2, "1x forward net");
        p0 = pos;
        walk(0, 8, 4); repeat (4) @(negedge clk);
        check("R8", pos - p0, -2, "1x reverse net");

        // R10: chatter on A at B=1 in 1x, on A in 2x, on B in 4x
        cur_req = "R10";
        drive(0, 1, 5); p0 = pos;
        for (int i = 0; i < 6; i++) drive(~phase_a, 1, 1 + i % 2);
        repeat (5) @(negedge clk);
        check("R10", pos - p0, 0, "1x chatter net");
        res_mode = 2'b01; p0 = pos;
        for (int i = 0; i < 8; i++) drive(~phase_a, 1, 1);
        repeat (5) @(negedge clk);
        check("R10", pos - p0, 0, "2x chatter net");
        res_mode = 2'b10; drive(1, 0, 5); p0 = pos;
        for (int i = 0; i < 6; i++) drive(1, ~phase_b, 2);
        repeat (5) @(negedge clk);
        check("R10", pos - p0, 0, "4x chatter net");

        // R5: double change is dropped, history still updates
        cur_req = "R5";
        drive(0, 0, 6); p0 = pos;
        drive(1, 1, 6);
        check("R5", pos - p0, 0, "double change no count");
        drive(0, 1, 6);
        check("R5", pos - p0, 1, "next move from new history");
        check("R3", step_up, 1, "11->01 is up");

        // R2: reset in the middle with phases high
        cur_req = "R2";
        drive(1, 1, 2);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R2", step_en, 0, "mid reset en");
        check("R2", step_up, 0, "mid reset up");
        rst_n = 1'b1; p0 = pos;
        repeat (6) @(negedge clk);
        check("R2", pos - p0, 0, "cleared history sees double change");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule